// File: doc/BRIEF.md
# Fetch Branch Target Buffer with Direction Predictor

This block predicts the next fetch address of a pipelined processor. It keeps a small direct-mapped table indexed by low bits of the fetch address. Each entry holds a valid flag, an address tag, a branch target and a direction state. Every cycle the fetch address is looked up combinationally. A hit whose state predicts taken steers fetch to the stored target in the same cycle, so a correctly predicted taken branch costs no cycles. Any other case falls through to the sequential address.

When a branch resolves in the execute stage, its address, outcome, target and the prediction made for it at fetch come back on the update port. The block trains the matching entry, or allocates one for a taken branch that missed. One cycle later it raises a redirect with the correct next address if the prediction was wrong in direction or in target. A parameter selects the direction policy: a single last-outcome bit, or a two-bit saturating counter that adds hysteresis. Flushing the pipeline is left to the consumer of the redirect.

Top module: `fetch_btb`

## Requirements
- R1: When the fetch lookup misses (entry invalid or tag differs), `fetch_hit_o` is 0, `fetch_pred_taken_o` is 0 and `fetch_next_pc_o` equals `fetch_pc_i + 4`, in the same cycle.
- R2: When the lookup hits an entry whose state predicts taken, `fetch_pred_taken_o` is 1 and `fetch_next_pc_o` is the stored target in the same cycle. A hit predicting not-taken gives `fetch_pc_i + 4`.
- R3: With `PRED_BITS=2` the state is a counter: 0 and 1 predict not-taken, 2 and 3 predict taken. A taken outcome increments it and a not-taken outcome decrements it, saturating at 3 and at 0.
- R4: With `PRED_BITS=1` the prediction for a hit entry equals the outcome of the last resolved update of that entry.
- R5: With `PRED_BITS=2` an entry that predicts taken with state 3 keeps predicting taken after one not-taken outcome and predicts not-taken only after a second one.
- R6: In the cycle after an update, `redirect_valid_o` is 1 exactly when the actual outcome differs from `upd_pred_taken_i`, or when both are taken and `upd_pred_target_i` differs from `upd_target_i`. `redirect_pc_o` is then `upd_target_i` when taken, else `upd_pc_i + 4`. Otherwise `redirect_valid_o` is 0.
- R7: A taken update that misses writes a new entry with the weakly-taken state (2 in two-bit mode, 1 in one-bit mode), replacing any entry at that index. A not-taken update that misses changes nothing.
- R8: The index is `pc[log2(ENTRIES)+1:2]` and the tag is all bits above it. Addresses differing only in index bits or only in tag bits do not alias.
- R9: Reset clears every valid flag and the redirect output, so every lookup after reset misses until a taken update allocates.
- R10: If an update writes the entry being looked up in the same cycle, the lookup returns the contents from before the write. The new contents are seen from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| fetch_pc_i | input | ADDR_W | Address being fetched |
| fetch_hit_o | output | 1 | Lookup found a valid matching entry |
| fetch_pred_taken_o | output | 1 | Lookup predicts taken |
| fetch_next_pc_o | output | ADDR_W | Predicted next fetch address |
| upd_valid_i | input | 1 | A resolved branch is presented |
| upd_pc_i | input | ADDR_W | Address of the resolved branch |
| upd_taken_i | input | 1 | Actual direction |
| upd_target_i | input | ADDR_W | Actual target |
| upd_pred_taken_i | input | 1 | Direction predicted at fetch |
| upd_pred_target_i | input | ADDR_W | Next address predicted at fetch when taken |
| redirect_valid_o | output | 1 | Registered mispredict indication |
| redirect_pc_o | output | ADDR_W | Correct next address for the redirect |

## Verification
The bench builds two copies with `ENTRIES=8` side by side, one with `PRED_BITS=2` and one with `PRED_BITS=1`. Both get the same branch history, so one sequence shows where the last-outcome bit flips and the counter holds. It also shows saturation at both counter ends. The small table puts addresses 32 bytes apart on the same index with different tags. This covers tag conflicts, replacement on allocation, the no-allocation rule for not-taken misses, and the same-cycle lookup and update of one entry.

// File: rtl/btb_pkg.sv
package btb_pkg;

  localparam int unsigned INSTR_BYTES = 4;
  localparam int unsigned PC_OFS      = $clog2(INSTR_BYTES);

  // what an update does to the table
  typedef enum logic [1:0] {
    ACT_IDLE  = 2'd0,
    ACT_TRAIN = 2'd1,
    ACT_ALLOC = 2'd2
  } btb_act_e;

endpackage

// File: rtl/btb_pred.sv
module btb_pred #(
  parameter int PRED_BITS = 2,
  localparam int PW = PRED_BITS
) (
  input  logic [PW-1:0] cur_state,
  input  logic          outcome,
  output logic [PW-1:0] nxt_state,
  output logic          says_taken,
  output logic [PW-1:0] alloc_state
);

  // the most significant bit of the state is the direction in both policies
  assign says_taken  = cur_state[PW-1];
  assign alloc_state = {1'b1, {(PW-1){1'b0}}};

  generate
    if (PRED_BITS == 1) begin : g_last
      // hold when the outcome agrees, otherwise take the new outcome
      always_comb begin
        if (cur_state[0] == outcome) nxt_state = cur_state;
        else                         nxt_state = outcome;
      end
    end else begin : g_sat
      always_comb begin
        nxt_state = cur_state;
        if (outcome) begin
          if (cur_state != {PW{1'b1}}) nxt_state = cur_state + 1'b1;
        end else begin
          if (cur_state != {PW{1'b0}}) nxt_state = cur_state - 1'b1;
        end
      end
    end
  endgenerate

endmodule

// File: rtl/btb_table.sv
module btb_table #(
  parameter int ENTRIES = 16,
  parameter int TAG_W   = 26,
  parameter int TGT_W   = 32,
  parameter int PW      = 2,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             rst,
  // fetch read port
  input  logic [IDX_W-1:0] f_idx,
  output logic             f_valid,
  output logic [TAG_W-1:0] f_tag,
  output logic [TGT_W-1:0] f_tgt,
  output logic [PW-1:0]    f_state,
  // update read port
  input  logic [IDX_W-1:0] u_idx,
  output logic             u_valid,
  output logic [TAG_W-1:0] u_tag,
  output logic [TGT_W-1:0] u_tgt,
  output logic [PW-1:0]    u_state,
  // write port
  input  logic             we,
  input  logic             set_valid,
  input  logic [IDX_W-1:0] w_idx,
  input  logic [TAG_W-1:0] w_tag,
  input  logic [TGT_W-1:0] w_tgt,
  input  logic [PW-1:0]    w_state
);

  logic [TAG_W-1:0] tag_mem [ENTRIES];
  logic [TGT_W-1:0] tgt_mem [ENTRIES];
  logic [PW-1:0]    st_mem  [ENTRIES];
  logic [ENTRIES-1:0] valid_q;

  // payload storage: no reset so it maps to distributed RAM
  always_ff @(posedge clk) begin
    if (we) begin
      tag_mem[w_idx] <= w_tag;
      tgt_mem[w_idx] <= w_tgt;
      st_mem[w_idx]  <= w_state;
    end
  end

  // valid flags live in flops so reset can clear them all at once
  generate
    for (genvar e = 0; e < ENTRIES; e++) begin : g_vld
      always_ff @(posedge clk) begin
        if (rst)                                    valid_q[e] <= 1'b0;
        else if (we && set_valid && w_idx == IDX_W'(e)) valid_q[e] <= 1'b1;
      end
    end
  endgenerate

  // asynchronous reads return pre-write contents during a write cycle
  assign f_valid = valid_q[f_idx];
  assign f_tag   = tag_mem[f_idx];
  assign f_tgt   = tgt_mem[f_idx];
  assign f_state = st_mem[f_idx];

  assign u_valid = valid_q[u_idx];
  assign u_tag   = tag_mem[u_idx];
  assign u_tgt   = tgt_mem[u_idx];
  assign u_state = st_mem[u_idx];

  // R9
  valid_clear_chk: assert property (@(posedge clk) $past(rst) |-> (valid_q == '0));

  // R7
  alloc_sets_valid_chk: assert property (@(posedge clk) disable iff (rst)
    (we && set_valid) |=> valid_q[$past(w_idx)]);

endmodule

// File: rtl/btb_resolve.sv
module btb_resolve #(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              upd_valid_i,
  input  logic [ADDR_W-1:0] upd_pc_i,
  input  logic              upd_taken_i,
  input  logic [ADDR_W-1:0] upd_target_i,
  input  logic              upd_pred_taken_i,
  input  logic [ADDR_W-1:0] upd_pred_target_i,
  output logic              redirect_valid_o,
  output logic [ADDR_W-1:0] redirect_pc_o
);
  import btb_pkg::*;

  logic              dir_wrong;
  logic              tgt_wrong;
  logic              mis;
  logic [ADDR_W-1:0] fix_pc;

  assign dir_wrong = upd_taken_i != upd_pred_taken_i;
  assign tgt_wrong = upd_taken_i && upd_pred_taken_i && (upd_pred_target_i != upd_target_i);
  assign mis       = upd_valid_i && (dir_wrong || tgt_wrong);
  assign fix_pc    = upd_taken_i ? upd_target_i : upd_pc_i + ADDR_W'(INSTR_BYTES);

  always_ff @(posedge clk) begin
    if (rst) begin
      redirect_valid_o <= 1'b0;
      redirect_pc_o    <= '0;
    end else begin
      redirect_valid_o <= mis;
      if (mis) redirect_pc_o <= fix_pc;
    end
  end

  // R6
  redirect_cause_chk: assert property (@(posedge clk) disable iff (rst)
    redirect_valid_o |-> $past(upd_valid_i));

endmodule

// File: rtl/fetch_btb.sv
module fetch_btb #(
  parameter int ADDR_W    = 32,
  parameter int ENTRIES   = 16,
  parameter int PRED_BITS = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] fetch_pc_i,
  output logic              fetch_hit_o,
  output logic              fetch_pred_taken_o,
  output logic [ADDR_W-1:0] fetch_next_pc_o,
  input  logic              upd_valid_i,
  input  logic [ADDR_W-1:0] upd_pc_i,
  input  logic              upd_taken_i,
  input  logic [ADDR_W-1:0] upd_target_i,
  input  logic              upd_pred_taken_i,
  input  logic [ADDR_W-1:0] upd_pred_target_i,
  output logic              redirect_valid_o,
  output logic [ADDR_W-1:0] redirect_pc_o
);
  import btb_pkg::*;

  localparam int IDX_W = $clog2(ENTRIES);
  localparam int LO    = PC_OFS;
  localparam int TAG_W = ADDR_W - IDX_W - LO;
  localparam int PW    = PRED_BITS;

  // ---------------- fetch lookup ----------------
  logic [IDX_W-1:0]  f_idx;
  logic [TAG_W-1:0]  f_tag_pc;
  logic              f_valid;
  logic [TAG_W-1:0]  f_tag;
  logic [ADDR_W-1:0] f_tgt;
  logic [PW-1:0]     f_state;
  logic              f_hit;
  logic              f_dir;
  logic [PW-1:0]     f_nxt_unused;
  logic [PW-1:0]     f_alloc_unused;

  // ---------------- update side ----------------
  logic [IDX_W-1:0]  u_idx;
  logic [TAG_W-1:0]  u_tag_pc;
  logic              u_valid;
  logic [TAG_W-1:0]  u_tag;
  logic [ADDR_W-1:0] u_tgt;
  logic [PW-1:0]     u_state;
  logic              u_hit;
  logic [PW-1:0]     train_state;
  logic [PW-1:0]     alloc_state;
  logic              u_dir_unused;
  btb_act_e          act;

  logic              w_en;
  logic              w_set_valid;
  logic [ADDR_W-1:0] w_tgt;
  logic [PW-1:0]     w_state;

  assign f_idx    = fetch_pc_i[IDX_W+LO-1:LO];
  assign f_tag_pc = fetch_pc_i[ADDR_W-1:IDX_W+LO];
  assign u_idx    = upd_pc_i[IDX_W+LO-1:LO];
  assign u_tag_pc = upd_pc_i[ADDR_W-1:IDX_W+LO];

  btb_table #(
    .ENTRIES (ENTRIES),
    .TAG_W   (TAG_W),
    .TGT_W   (ADDR_W),
    .PW      (PW)
  ) u_table (
    .clk       (clk),
    .rst       (rst),
    .f_idx     (f_idx),
    .f_valid   (f_valid),
    .f_tag     (f_tag),
    .f_tgt     (f_tgt),
    .f_state   (f_state),
    .u_idx     (u_idx),
    .u_valid   (u_valid),
    .u_tag     (u_tag),
    .u_tgt     (u_tgt),
    .u_state   (u_state),
    .we        (w_en),
    .set_valid (w_set_valid),
    .w_idx     (u_idx),
    .w_tag     (u_tag_pc),
    .w_tgt     (w_tgt),
    .w_state   (w_state)
  );

  // direction read at fetch
  btb_pred #(.PRED_BITS(PRED_BITS)) u_fetch_pred (
    .cur_state   (f_state),
    .outcome     (1'b0),
    .nxt_state   (f_nxt_unused),
    .says_taken  (f_dir),
    .alloc_state (f_alloc_unused)
  );

  // training of the resolved entry
  btb_pred #(.PRED_BITS(PRED_BITS)) u_train_pred (
    .cur_state   (u_state),
    .outcome     (upd_taken_i),
    .nxt_state   (train_state),
    .says_taken  (u_dir_unused),
    .alloc_state (alloc_state)
  );

  assign f_hit              = f_valid && (f_tag == f_tag_pc);
  assign fetch_hit_o        = f_hit;
  assign fetch_pred_taken_o = f_hit && f_dir;
  assign fetch_next_pc_o    = fetch_pred_taken_o ? f_tgt
                                                 : fetch_pc_i + ADDR_W'(INSTR_BYTES);

  assign u_hit = u_valid && (u_tag == u_tag_pc);

  always_comb begin
    if (!upd_valid_i)     act = ACT_IDLE;
    else if (u_hit)       act = ACT_TRAIN;
    else if (upd_taken_i) act = ACT_ALLOC;
    else                  act = ACT_IDLE;
  end

  always_comb begin
    w_en        = 1'b0;
    w_set_valid = 1'b0;
    w_tgt       = u_tgt;
    w_state     = u_state;
    unique case (act)
      ACT_TRAIN: begin
        w_en    = 1'b1;
        w_state = train_state;
        if (upd_taken_i) w_tgt = upd_target_i;
      end
      ACT_ALLOC: begin
        w_en        = 1'b1;
        w_set_valid = 1'b1;
        w_tgt       = upd_target_i;
        w_state     = alloc_state;
      end
      default: ;
    endcase
  end

  btb_resolve #(.ADDR_W(ADDR_W)) u_resolve (
    .clk               (clk),
    .rst               (rst),
    .upd_valid_i       (upd_valid_i),
    .upd_pc_i          (upd_pc_i),
    .upd_taken_i       (upd_taken_i),
    .upd_target_i      (upd_target_i),
    .upd_pred_taken_i  (upd_pred_taken_i),
    .upd_pred_target_i (upd_pred_target_i),
    .redirect_valid_o  (redirect_valid_o),
    .redirect_pc_o     (redirect_pc_o)
  );

  // R1
  miss_seq_chk: assert property (@(posedge clk) disable iff (rst)
    !fetch_hit_o |-> (!fetch_pred_taken_o &&
                      fetch_next_pc_o == fetch_pc_i + ADDR_W'(INSTR_BYTES)));

  // R3
  sat_up_chk: assert property (@(posedge clk) disable iff (rst)
    (act == ACT_TRAIN && upd_taken_i) |-> (train_state >= u_state));

  // R3
  sat_down_chk: assert property (@(posedge clk) disable iff (rst)
    (act == ACT_TRAIN && !upd_taken_i) |-> (train_state <= u_state));

  // R9
  empty_after_reset_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> !fetch_hit_o);

endmodule

// File: tb/fetch_btb_bench.sv
module fetch_btb_bench;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 32;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [AW-1:0] fpc = '0;
  logic upd_v = 1'b0, upd_tk = 1'b0, upd_p2 = 1'b0, upd_p1 = 1'b0;
  logic [AW-1:0] upd_pc = '0, upd_tgt = '0, upd_ptgt = '0;

  logic h2, t2, rv2, h1, t1, rv1;
  logic [AW-1:0] n2, rp2, n1, rp1;

  int compared = 0;
  int mismatched = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fetch_btb #(.ADDR_W(AW), .ENTRIES(8), .PRED_BITS(2)) u_fetch_btb (
    .clk(clk), .rst(rst), .fetch_pc_i(fpc),
    .fetch_hit_o(h2), .fetch_pred_taken_o(t2), .fetch_next_pc_o(n2),
    .upd_valid_i(upd_v), .upd_pc_i(upd_pc), .upd_taken_i(upd_tk),
    .upd_target_i(upd_tgt), .upd_pred_taken_i(upd_p2), .upd_pred_target_i(upd_ptgt),
    .redirect_valid_o(rv2), .redirect_pc_o(rp2));

  fetch_btb #(.ADDR_W(AW), .ENTRIES(8), .PRED_BITS(1)) u_fetch_btb_1b (
    .clk(clk), .rst(rst), .fetch_pc_i(fpc),
    .fetch_hit_o(h1), .fetch_pred_taken_o(t1), .fetch_next_pc_o(n1),
    .upd_valid_i(upd_v), .upd_pc_i(upd_pc), .upd_taken_i(upd_tk),
    .upd_target_i(upd_tgt), .upd_pred_taken_i(upd_p1), .upd_pred_target_i(upd_ptgt),
    .redirect_valid_o(rv1), .redirect_pc_o(rp1));

  typedef struct {
    logic          v2;
    logic [AW-1:0] p2;
    logic          v1;
    logic [AW-1:0] p1;
    string         req;
  } exp_t;
  exp_t exp_q[$];

  task automatic chk(input string req, input string what,
                     input logic [AW-1:0] act, input logic [AW-1:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // monitor: pops one expected redirect per update, just after the edge
  always @(posedge clk) begin
    #2;
    if (!rst && exp_q.size() > 0) begin
      exp_t e;
      e = exp_q.pop_front();
      chk(e.req, "redirect_valid 2b", AW'(rv2), AW'(e.v2));
      if (e.v2) chk(e.req, "redirect_pc 2b", rp2, e.p2);
      chk(e.req, "redirect_valid 1b", AW'(rv1), AW'(e.v1));
      if (e.v1) chk(e.req, "redirect_pc 1b", rp1, e.p1);
    end
  end

  function automatic logic wrong(input logic tk, input logic p,
                                 input logic [AW-1:0] tgt, input logic [AW-1:0] ptgt);
    return (tk != p) || (tk && p && tgt != ptgt);
  endfunction

  // drives signals for one cycle; caller is positioned after a falling edge
  task automatic drive_upd(input logic [AW-1:0] pc, input logic tk,
                           input logic [AW-1:0] tgt, input logic [AW-1:0] ptgt,
                           input logic p2, input logic p1, input string req);
    exp_t e;
    logic [AW-1:0] fix;
    fix = tk ? tgt : pc + 4;
    upd_v = 1'b1; upd_pc = pc; upd_tk = tk; upd_tgt = tgt; upd_ptgt = ptgt;
    upd_p2 = p2; upd_p1 = p1;
    e.v2 = wrong(tk, p2, tgt, ptgt); e.p2 = fix;
    e.v1 = wrong(tk, p1, tgt, ptgt); e.p1 = fix;
    e.req = req;
    exp_q.push_back(e);
  endtask

  task automatic upd(input logic [AW-1:0] pc, input logic tk,
                     input logic [AW-1:0] tgt, input logic [AW-1:0] ptgt,
                     input logic p2, input logic p1, input string req);
    @(negedge clk);
    drive_upd(pc, tk, tgt, ptgt, p2, p1, req);
    @(negedge clk);
    upd_v = 1'b0;
  endtask

  task automatic look(input logic [AW-1:0] pc,
                      input logic eh2, input logic et2,
                      input logic eh1, input logic et1,
                      input logic [AW-1:0] tgt, input string req);
    @(negedge clk);
    fpc = pc;
    #1;
    chk(req, "hit 2b",   AW'(h2), AW'(eh2));
    chk(req, "taken 2b", AW'(t2), AW'(et2));
    chk(req, "next 2b",  n2, et2 ? tgt : pc + 4);
    chk(req, "hit 1b",   AW'(h1), AW'(eh1));
    chk(req, "taken 1b", AW'(t1), AW'(et1));
    chk(req, "next 1b",  n1, et1 ? tgt : pc + 4);
  endtask

  localparam logic [AW-1:0] PA = 32'h0000_0100;
  localparam logic [AW-1:0] TA = 32'h0000_0200;
  localparam logic [AW-1:0] PB = 32'h0000_0120; // same index as PA, other tag
  localparam logic [AW-1:0] TB = 32'h0000_0400;
  localparam logic [AW-1:0] PC1 = 32'h0000_0104; // neighbouring index

  bit done = 1'b0;

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R9 reset state
    chk("R9", "redirect_valid 2b", AW'(rv2), '0);
    chk("R9", "redirect_valid 1b", AW'(rv1), '0);
    look(PA, 0, 0, 0, 0, TA, "R1");
    look(PA, 0, 0, 0, 0, TA, "R9");

    // first taken: mispredict from miss, allocate weakly taken (R6, R7)
    upd(PA, 1, TA, '0, 0, 0, "R6");
    look(PA, 1, 1, 1, 1, TA, "R2");
    look(PC1, 0, 0, 0, 0, TA, "R8");
    look(PB, 0, 0, 0, 0, TA, "R8");

    // 2b: 10 -> 11; then one not-taken
    upd(PA, 1, TA, TA, 1, 1, "R6");
    upd(PA, 0, TA, TA, 1, 1, "R6");
    look(PA, 1, 1, 1, 0, TA, "R5");
    look(PA, 1, 1, 1, 0, TA, "R4");
    // second not-taken flips the counter
    upd(PA, 0, TA, TA, 1, 0, "R6");
    look(PA, 1, 0, 1, 0, TA, "R5");

    // low saturation: 01 -> 00 -> 00, then taken -> 01
    upd(PA, 0, TA, TA, 0, 0, "R3");
    upd(PA, 0, TA, TA, 0, 0, "R3");
    upd(PA, 1, TA, TA, 0, 0, "R6");
    look(PA, 1, 0, 1, 1, TA, "R3");
    look(PA, 1, 0, 1, 1, TA, "R4");

    // target mismatch with right direction (1b), direction wrong (2b)
    upd(PA, 1, TA, 32'h0000_0300, 0, 1, "R6");
    // 10 -> 11 -> 11 (high saturation), then one not-taken keeps taken
    upd(PA, 1, TA, TA, 1, 1, "R3");
    upd(PA, 1, TA, TA, 1, 1, "R3");
    upd(PA, 0, TA, TA, 1, 1, "R6");
    look(PA, 1, 1, 1, 0, TA, "R3");

    // conflict: not-taken miss does not allocate
    look(PB, 0, 0, 0, 0, TB, "R8");
    upd(PB, 0, TB, '0, 0, 0, "R7");
    look(PB, 0, 0, 0, 0, TB, "R7");
    look(PA, 1, 1, 1, 0, TA, "R7");
    // taken miss replaces the entry at the shared index
    upd(PB, 1, TB, '0, 0, 0, "R7");
    look(PA, 0, 0, 0, 0, TA, "R7");
    look(PB, 1, 1, 1, 1, TB, "R7");

    // same-cycle lookup and update of one entry
    @(negedge clk);
    fpc = PB;
    drive_upd(PB, 0, TB, TB, 1, 1, "R6");
    #1;
    chk("R10", "old taken 2b", AW'(t2), 1);
    chk("R10", "old next 2b", n2, TB);
    chk("R10", "old taken 1b", AW'(t1), 1);
    chk("R10", "old next 1b", n1, TB);
    @(negedge clk);
    upd_v = 1'b0;
    look(PB, 1, 0, 1, 0, TB, "R10");

    // reset clears the table again
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    look(PB, 0, 0, 0, 0, TB, "R9");

    repeat (2) @(negedge clk);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      compared++;
      mismatched++;
      $display("FAIL watchdog: actual running expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

endmodule